// File: doc/BRIEF.md
# Bit-Sliced Arithmetic Logic Unit with Overflow Flag

This block is a purely combinational N-bit ALU assembled from identical one-bit cells. Each cell holds an AND gate, an OR gate, a full adder and an output selector. The cells are linked by a ripple carry. A 3-bit opcode picks one of eight operations: two bitwise functions, inversion of A, add and subtract in signed and unsigned flavours, and a signed set-less-than.

Subtraction uses the same adder. B passes through a per-cell selectable inverter, and a 1 is fed into the carry input of bit 0, so the chain computes A plus the two's complement of B. A separate flag unit looks at the top slice and the final carry and produces an overflow flag for a CPU exception unit. For unsigned work the flag is the final carry. For signed work it is a sign mismatch between the adder inputs and the sum.

The block holds no state. Its outputs follow its inputs within one propagation delay through the carry chain.

Top module: `bitslice_alu`

## Requirements
- R1: Opcode 000 gives y_o equal to the bitwise AND of a_i and b_i.
- R2: Opcode 001 gives y_o equal to the bitwise OR of a_i and b_i.
- R3: Opcode 101 gives y_o equal to the bitwise inverse of a_i; b_i has no effect on y_o.
- R4: Opcode 010 (signed add) gives y_o = (a_i + b_i) mod 2^WIDTH.
- R5: Opcode 011 (signed subtract) gives y_o = (a_i - b_i) mod 2^WIDTH.
- R6: Opcodes 110 (unsigned add) and 111 (unsigned subtract) give the same y_o as 010 and 011 respectively.
- R7: carry_o is the carry out of the most significant cell for every opcode. The chain computes a_i + ~b_i + 1 for opcodes 011, 100 and 111, and a_i + b_i for all other opcodes.
- R8: For opcodes 010 and 011, ovf_o is 1 exactly when the top bit of a_i and the top bit of the adder's B input (b_i, or ~b_i when subtracting) are equal and the top sum bit differs from them.
- R9: For opcodes 110 and 111, ovf_o equals carry_o.
- R10: For opcodes 000, 001, 100 and 101, ovf_o is 0.
- R11: Opcode 100 gives y_o = 1 when a_i is less than b_i as signed two's complement numbers, and 0 otherwise. Bits above bit 0 are always 0, and the result is correct even when a_i - b_i overflows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B |
| op_i | input | 3 | Operation code |
| y_o | output | WIDTH | Result |
| carry_o | output | 1 | Carry out of the top cell |
| ovf_o | output | 1 | Overflow flag for the exception unit |

## Verification
Signed overflow and set-less-than can occur in the same evaluation. Opcode 100 runs the subtraction whose overflow must correct the sign bit, while the overflow flag itself must stay at 0. The exhaustive sweep at width 4 provokes this with pairs such as A = -8 and B = 1, or A = 7 and B = -1. For each pair, a reference model computes the less-than result from signed comparison and expects ovf_o to be 0, and the scoreboard compares both values in the same sample.

// File: rtl/alu_pkg.sv
// Shared types for the bit-sliced ALU: the opcode map, the per-cell
// output selector and the decoded control bundle.
package alu_pkg;

    typedef enum logic [2:0] {
        OP_AND  = 3'b000,
        OP_OR   = 3'b001,
        OP_ADD  = 3'b010,
        OP_SUB  = 3'b011,
        OP_SLT  = 3'b100,
        OP_NOTA = 3'b101,
        OP_ADDU = 3'b110,
        OP_SUBU = 3'b111
    } opcode_e;

    typedef enum logic [2:0] {
        SEL_AND  = 3'd0,
        SEL_OR   = 3'd1,
        SEL_SUM  = 3'd2,
        SEL_NOTA = 3'd3,
        SEL_LESS = 3'd4
    } cell_sel_e;

    typedef struct packed {
        cell_sel_e sel;        // what every cell drives to its result bit
        logic      b_invert;   // invert B and inject carry-in of 1
        logic      chk_signed; // overflow by sign mismatch
        logic      chk_unsigned; // overflow by final carry
    } alu_ctrl_t;

endpackage

// File: rtl/alu_ctrl.sv
// Opcode decoder. Maps the 3-bit opcode onto the cell selector, the
// subtract control and the choice of overflow rule.
// Assumes: none; every opcode value is defined.
module alu_ctrl
    import alu_pkg::*;
(
    input  logic [2:0] op_i,
    output alu_ctrl_t  ctrl_o
);

    // Decode the opcode into the control bundle.
    always_comb begin
        ctrl_o = '{sel: SEL_AND, b_invert: 1'b0, chk_signed: 1'b0, chk_unsigned: 1'b0};
        unique case (opcode_e'(op_i))
            OP_AND:  ctrl_o.sel = SEL_AND;
            OP_OR:   ctrl_o.sel = SEL_OR;
            OP_ADD:  begin ctrl_o.sel = SEL_SUM; ctrl_o.chk_signed = 1'b1; end
            OP_SUB:  begin ctrl_o.sel = SEL_SUM; ctrl_o.b_invert = 1'b1; ctrl_o.chk_signed = 1'b1; end
            OP_SLT:  begin ctrl_o.sel = SEL_LESS; ctrl_o.b_invert = 1'b1; end
            OP_NOTA: ctrl_o.sel = SEL_NOTA;
            OP_ADDU: begin ctrl_o.sel = SEL_SUM; ctrl_o.chk_unsigned = 1'b1; end
            OP_SUBU: begin ctrl_o.sel = SEL_SUM; ctrl_o.b_invert = 1'b1; ctrl_o.chk_unsigned = 1'b1; end
            default: ctrl_o.sel = SEL_AND;
        endcase
    end

endmodule

// File: rtl/alu_bit_cell.sv
// One slice of the ALU: AND, OR, a full adder behind a selectable B
// inverter, and an output selector. Exposes the raw sum, the carry out
// and the adder's effective B bit so the flag unit can inspect the top slice.
// Assumes: less_i is 0 on every slice except bit 0.
module alu_bit_cell
    import alu_pkg::*;
(
    input  logic      a_i,
    input  logic      b_i,
    input  logic      b_invert_i,
    input  logic      cin_i,
    input  logic      less_i,
    input  cell_sel_e sel_i,
    output logic      res_o,
    output logic      sum_o,
    output logic      b_eff_o,
    output logic      cout_o
);

    // Full adder on A and the optionally inverted B.
    always_comb begin
        b_eff_o = b_i ^ b_invert_i;
        sum_o   = a_i ^ b_eff_o ^ cin_i;
        cout_o  = (a_i & b_eff_o) | (cin_i & (a_i ^ b_eff_o));
    end

    // Output selector for this slice.
    always_comb begin
        unique case (sel_i)
            SEL_AND:  res_o = a_i & b_i;
            SEL_OR:   res_o = a_i | b_i;
            SEL_SUM:  res_o = sum_o;
            SEL_NOTA: res_o = ~a_i;
            SEL_LESS: res_o = less_i;
            default:  res_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/alu_flag_unit.sv
// Overflow and less-than logic fed from the most significant slice.
// Signed rule: both adder inputs share a sign the sum lacks. Unsigned
// rule: the final carry. The less-than bit is sum sign XOR signed overflow.
// Assumes: b_msb_i is taken after the subtract inverter.
module alu_flag_unit (
    input  logic chk_signed_i,
    input  logic chk_unsigned_i,
    input  logic a_msb_i,
    input  logic b_msb_i,
    input  logic s_msb_i,
    input  logic cout_i,
    output logic ovf_o,
    output logic less_o
);

    logic sgn_ovf;

    // Sign-mismatch detector, also used to correct the less-than bit.
    always_comb begin
        sgn_ovf = (a_msb_i & b_msb_i & ~s_msb_i) | (~a_msb_i & ~b_msb_i & s_msb_i);
        less_o  = s_msb_i ^ sgn_ovf;
    end

    // Choose the overflow rule by signedness; other operations report none.
    always_comb begin
        ovf_o = (chk_signed_i & sgn_ovf) | (chk_unsigned_i & cout_i);
    end

endmodule

// File: rtl/bitslice_alu.sv
// Top of the bit-sliced ALU. WIDTH identical cells share a ripple carry.
// Bit 0's carry-in is the subtract control. The flag unit closes the
// loop to bit 0 for set-less-than.
// Assumes: purely combinational use; no clock or reset in this block.
module bitslice_alu
    import alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [2:0]       op_i,
    output logic [WIDTH-1:0] y_o,
    output logic             carry_o,
    output logic             ovf_o
);

    localparam int MSB = WIDTH - 1;

    alu_ctrl_t        ctrl;
    logic             carry [WIDTH+1];
    logic [WIDTH-1:0] sum;
    logic [WIDTH-1:0] b_eff;
    logic             less_bit;

    alu_ctrl u_ctrl (
        .op_i   (op_i),
        .ctrl_o (ctrl)
    );

    // Carry-in of the chain is 1 when subtracting.
    always_comb carry[0] = ctrl.b_invert;

    for (genvar gi = 0; gi < WIDTH; gi++) begin : g_cell
        logic less_in;
        if (gi == 0) begin : g_lsb
            always_comb less_in = less_bit;
        end else begin : g_upper
            always_comb less_in = 1'b0;
        end
        alu_bit_cell u_cell (
            .a_i        (a_i[gi]),
            .b_i        (b_i[gi]),
            .b_invert_i (ctrl.b_invert),
            .cin_i      (carry[gi]),
            .less_i     (less_in),
            .sel_i      (ctrl.sel),
            .res_o      (y_o[gi]),
            .sum_o      (sum[gi]),
            .b_eff_o    (b_eff[gi]),
            .cout_o     (carry[gi+1])
        );
    end

    alu_flag_unit u_flags (
        .chk_signed_i   (ctrl.chk_signed),
        .chk_unsigned_i (ctrl.chk_unsigned),
        .a_msb_i        (a_i[MSB]),
        .b_msb_i        (b_eff[MSB]),
        .s_msb_i        (sum[MSB]),
        .cout_i         (carry[WIDTH]),
        .ovf_o          (ovf_o),
        .less_o         (less_bit)
    );

    // Final carry goes straight to the port.
    always_comb carry_o = carry[WIDTH];

endmodule

// File: rtl/bitslice_alu_chk.sv
// Checker for the bit-sliced ALU, bound to every instance of the top.
// Immediate assertions on the settled combinational outputs.
module bitslice_alu_chk #(
    parameter int WIDTH = 8
) (
    input logic [WIDTH-1:0] a_i,
    input logic [WIDTH-1:0] b_i,
    input logic [2:0]       op_i,
    input logic [WIDTH-1:0] y_o,
    input logic             carry_o,
    input logic             ovf_o
);

    // Port-level relations between the cells, the chain and the flag unit.
    always_comb begin
        if (op_i == 3'b000) begin
            p_and_r1: assert (y_o == (a_i & b_i)) else $error("R1 AND result wrong");
        end
        if (op_i == 3'b101) begin
            p_nota_r3: assert (y_o == ~a_i) else $error("R3 NOT A result wrong");
        end
        if (op_i[2:1] == 2'b11) begin
            p_unsigned_ovf_r9: assert (ovf_o == carry_o) else $error("R9 unsigned overflow differs from carry");
        end
        if (op_i == 3'b000 || op_i == 3'b001 || op_i == 3'b100 || op_i == 3'b101) begin
            p_no_overflow_r10: assert (!ovf_o) else $error("R10 overflow raised for non-arithmetic op");
        end
        if (op_i == 3'b100) begin
            p_slt_upper_zero_r11: assert (y_o[WIDTH-1:1] == '0) else $error("R11 upper less-than bits set");
        end
    end

endmodule

bind bitslice_alu bitslice_alu_chk #(.WIDTH(WIDTH)) u_chk (
    .a_i     (a_i),
    .b_i     (b_i),
    .op_i    (op_i),
    .y_o     (y_o),
    .carry_o (carry_o),
    .ovf_o   (ovf_o)
);

// File: tb/bitslice_alu_tb.sv
// Scoreboard bench: the driver applies every opcode and operand pair at
// width 4 and queues the reference result; the monitor compares on the
// falling edge.
module bitslice_alu_tb;

    localparam int W = 4;
    localparam int N = 1 << W;

    typedef struct {
        logic [2:0]   op;
        logic [W-1:0] y;
        logic         c;
        logic         v;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a = '0;
    logic [W-1:0] b = '0;
    logic [2:0]   op = 3'b000;
    logic [W-1:0] y;
    logic         carry;
    logic         ovf;

    int   n_chk = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;
    exp_t sb_q[$];

    always #4 clk = ~clk; // 125 MHz

    bitslice_alu #(.WIDTH(W)) u_dut (
        .a_i (a), .b_i (b), .op_i (op),
        .y_o (y), .carry_o (carry), .ovf_o (ovf)
    );

    // Reference model built from the requirements.
    function automatic exp_t model(input logic [2:0] o, input logic [W-1:0] x, input logic [W-1:0] z);
        exp_t e;
        logic         sub;
        logic [W-1:0] bb;
        logic [W:0]   full;
        logic         sov;
        sub  = (o == 3'b011) || (o == 3'b100) || (o == 3'b111);
        bb   = sub ? ~z : z;
        full = {1'b0, x} + {1'b0, bb} + {{W{1'b0}}, sub};
        sov  = (x[W-1] == bb[W-1]) && (full[W-1] != x[W-1]);
        e.op = o;
        e.c  = full[W];
        case (o)
            3'b000:  e.y = x & z;
            3'b001:  e.y = x | z;
            3'b100:  e.y = ($signed(x) < $signed(z)) ? W'(1) : '0;
            3'b101:  e.y = ~x;
            3'b010, 3'b110: e.y = x + z;
            default: e.y = x - z;
        endcase
        case (o)
            3'b010, 3'b011: e.v = sov;
            3'b110, 3'b111: e.v = full[W];
            default:        e.v = 1'b0;
        endcase
        return e;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp_v);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
        end
    endtask

    function automatic string res_tag(input logic [2:0] o);
        case (o)
            3'b000: return "R1";
            3'b001: return "R2";
            3'b010: return "R4";
            3'b011: return "R5";
            3'b100: return "R11";
            3'b101: return "R3";
            default: return "R6";
        endcase
    endfunction

    function automatic string ovf_tag(input logic [2:0] o);
        case (o)
            3'b010, 3'b011: return "R8";
            3'b110, 3'b111: return "R9";
            default:        return "R10";
        endcase
    endfunction

    // Driver: apply one vector at a rising edge and queue its expectation.
    task automatic drive(input logic [2:0] o, input logic [W-1:0] x, input logic [W-1:0] z);
        @(posedge clk);
        op = o; a = x; b = z;
        sb_q.push_back(model(o, x, z));
    endtask

    // Monitor: pop and compare on the falling edge.
    always @(negedge clk) begin
        if (rst_n && sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            check(y == e.y, res_tag(e.op), int'(y), int'(e.y));
            check(carry == e.c, "R7", int'(carry), int'(e.c));
            check(ovf == e.v, ovf_tag(e.op), int'(ovf), int'(e.v));
        end
    end

    // Stimulus: reset-time check, then the exhaustive sweep.
    initial begin
        repeat (2) @(negedge clk);
        check(y == '0 && !carry && !ovf, "R1", int'({y, carry, ovf}), 0);
        @(posedge clk);
        rst_n = 1'b1;
        for (int o = 0; o < 8; o++)
            for (int x = 0; x < N; x++)
                for (int z = 0; z < N; z++)
                    drive(3'(o), W'(x), W'(z));
        // R3: b_i ignored under NOT A, swept above; R11 overflow corners again.
        drive(3'b100, 4'h8, 4'h1);
        drive(3'b100, 4'h7, 4'hF);
        drive(3'b101, 4'h5, 4'hF);
        repeat (3) @(posedge clk);
        done = 1'b1;
    end

    // Watchdog and summary.
    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule